// File: doc/BRIEF.md
# IDE PIO Host Timing Sequencer

This block is the host side of a parallel ATA register and data port running in programmed I/O mode. A local requester gives it one access at a time: a five-bit device address, a read or write flag, a byte/word flag and, for writes, a data word. The sequencer then drives the active-low chip selects and address lines. It holds them for a setup time and pulls the read or write strobe low for the active width. It releases the strobe and waits out recovery and the full cycle minimum before it accepts the next access. Reads return the sampled bus value together with a one-cycle `done` pulse.

Seven transfer modes (0 to 6) are supported. Each mode has its own nanosecond minimums for setup, strobe width, recovery and total cycle. At elaboration these are turned into clock counts by rounding up against the `CLK_NS` parameter. The device can stretch any strobe by holding its ready line low. In modes 0 to 2 it can also report, through its 16-bit indicator, that a word access is really 8 bits wide. The mode is written through `mode_set`/`mode_val` and changes only while the sequencer is idle.

The controller has four states. The transitions between them are:

- **IDLE → SETUP**: `req_valid` is seen.
- **SETUP → STROBE**: the setup count has been reached.
- **STROBE → RECOVER**: the width count has been reached and the ready line is high.
- **RECOVER → IDLE**: the recovery count and the total cycle count have both been reached. This transition produces `done`.

Every other case stays in the current state.

Top module: `pio_host_seq`

## Requirements
- R1: After reset, `ide_cs_n`=2'b11, `ide_a`=0, both strobes are high, `ide_doe`=0, `done`=0, `req_ready`=1 and `active_mode`=0.
- R2: While busy, `ide_cs_n` equals the inverted `req_addr[4:3]` and `ide_a` equals `req_addr[2:0]`, both captured at acceptance and held stable. While idle, `ide_cs_n`=2'b11 and `ide_a`=0.
- R3: The strobe falls after exactly ceil(setup_ns/CLK_NS) cycles with the address valid. setup_ns is 70, 50, 30, 30, 25, 15 and 10 for modes 0 to 6.
- R4: Only one strobe is low at a time: `ide_rd_n` for reads, `ide_wr_n` for writes. With ready high, the strobe stays low for ceil(width_ns/CLK_NS) cycles. For word accesses width_ns is 165, 125, 100, 80, 70, 65 and 55 for modes 0 to 6. For byte accesses (`req_byte`=1) it is 290 in modes 0 to 2 and the word value in modes 3 to 6.
- R5: Once the minimum width has elapsed, the strobe stays low on every cycle in which `ide_rdy` is low. It is released at the first cycle where both conditions hold.
- R6: In modes 0 to 2, a word access with `ide_iocs16_n`=1 uses the byte strobe width and returns only the low 8 bits. In modes 3 to 6, `ide_iocs16_n` has no effect.
- R7: After the strobe rises, the strobe stays high for at least max(1, ceil(rec_ns/CLK_NS)) cycles, where rec_ns is 0, 0, 0, 70, 25, 25 and 20 for modes 0 to 6. The access (setup start to return to idle) lasts at least ceil(cyc_ns/CLK_NS) cycles, where cyc_ns is 600, 383, 240, 180, 120, 100 and 80. The sequencer returns to idle in the first cycle where both minimums are met.
- R8: A read captures `ide_din` on the last clock edge of the strobe. Bits 15:8 are zeroed for a byte or narrow access. `done` is high for exactly one cycle, the first idle cycle, with `rdata` valid.
- R9: A write drives `ide_dout`=`req_wdata` (bits 15:8 zeroed for a byte write). `ide_doe` is high from the first setup cycle through the first cycle after `ide_wr_n` rises, and low otherwise.
- R10: `mode_set` updates `active_mode` only in an idle cycle and only when `mode_val` is 0 to 6. A request accepted in the same cycle already uses the new mode.
- R11: `req_ready` is high only while idle. `req_valid` seen while busy is ignored and starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, accepted when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | {select1, select0, register[2:0]} |
| req_byte | input | 1 | 8-bit register access |
| req_wdata | input | 16 | Write data |
| mode_set | input | 1 | Load a new transfer mode |
| mode_val | input | 3 | Requested mode, 0 to 6 |
| req_ready | output | 1 | Sequencer idle |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result |
| active_mode | output | 3 | Mode in force |
| ide_cs_n | output | 2 | Active-low chip selects |
| ide_a | output | 3 | Register address lines |
| ide_rd_n | output | 1 | Active-low read strobe |
| ide_wr_n | output | 1 | Active-low write strobe |
| ide_dout | output | 16 | Data driven to the bus |
| ide_doe | output | 1 | Data output enable |
| ide_din | input | 16 | Data sampled from the bus |
| ide_rdy | input | 1 | Device ready; low stretches the strobe |
| ide_iocs16_n | input | 1 | Device 16-bit indicator, active low |

## Verification
The assertions assume the following about the inputs:

- `ide_rdy` and `ide_iocs16_n` change only between clock edges.
- `ide_din` is stable at the capturing edge.
- The ready line is eventually returned high.

The stimulus updates every device-side input on the falling clock edge. It derives `ide_din` from the address pins seen on that edge. It releases each ready stall after a fixed number of cycles, and it holds `ide_iocs16_n` constant for the length of each access.

// File: rtl/pio_pkg.sv
`timescale 1ns/1ps
package pio_pkg;
    localparam int TCW       = 16;
    localparam int NUM_MODES = 7;
    localparam int MODE_W    = 3;
    localparam int SEL_W     = 2;
    localparam int REG_W     = 3;
    localparam int ADDR_W    = SEL_W + REG_W;
    localparam int DATA_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int NARROW_MAX_MODE = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_RECOVER
    } pio_state_e;

    typedef struct packed {
        logic [TCW-1:0] setup;
        logic [TCW-1:0] pulse_w;
        logic [TCW-1:0] pulse_b;
        logic [TCW-1:0] recov;
        logic [TCW-1:0] cycle;
    } pio_timing_t;

    function automatic int setup_ns(input int m);
        case (m)
            0: return 70;
            1: return 50;
            2: return 30;
            3: return 30;
            4: return 25;
            5: return 15;
            default: return 10;
        endcase
    endfunction

    function automatic int word_ns(input int m);
        case (m)
            0: return 165;
            1: return 125;
            2: return 100;
            3: return 80;
            4: return 70;
            5: return 65;
            default: return 55;
        endcase
    endfunction

    function automatic int byte_ns(input int m);
        return (m <= NARROW_MAX_MODE) ? 290 : word_ns(m);
    endfunction

    function automatic int recov_ns(input int m);
        case (m)
            3: return 70;
            4: return 25;
            5: return 25;
            6: return 20;
            default: return 0;
        endcase
    endfunction

    function automatic int cycle_ns(input int m);
        case (m)
            0: return 600;
            1: return 383;
            2: return 240;
            3: return 180;
            4: return 120;
            5: return 100;
            default: return 80;
        endcase
    endfunction

    function automatic logic [TCW-1:0] ns_to_clk(input int ns, input int clk_ns);
        return TCW'((ns + clk_ns - 1) / clk_ns);
    endfunction

    function automatic pio_timing_t make_timing(input int m, input int clk_ns);
        pio_timing_t t;
        t.setup   = ns_to_clk(setup_ns(m), clk_ns);
        t.pulse_w = ns_to_clk(word_ns(m),  clk_ns);
        t.pulse_b = ns_to_clk(byte_ns(m),  clk_ns);
        t.recov   = ns_to_clk(recov_ns(m), clk_ns);
        t.cycle   = ns_to_clk(cycle_ns(m), clk_ns);
        return t;
    endfunction
endpackage

// File: rtl/pio_timing_lut.sv
`timescale 1ns/1ps
module pio_timing_lut
    import pio_pkg::*;
#(
    parameter int CLK_NS = 10
) (
    input  logic [MODE_W-1:0] mode,
    output pio_timing_t       tim
);
    localparam int LUT_N = 2 ** MODE_W;

    pio_timing_t lut [LUT_N];

    for (genvar m = 0; m < LUT_N; m++) begin : g_mode
        localparam int MM = (m < NUM_MODES) ? m : NUM_MODES - 1;
        assign lut[m] = make_timing(MM, CLK_NS);
    end

    assign tim = lut[mode];
endmodule

// File: rtl/pio_seq_fsm.sv
`timescale 1ns/1ps
module pio_seq_fsm
    import pio_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_byte,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic                mode_set,
    input  logic [MODE_W-1:0]   mode_val,
    input  pio_timing_t         tim,
    output logic [MODE_W-1:0]   xfer_mode,
    output logic                req_ready,
    output logic                done,
    output logic [DATA_W-1:0]   rdata,
    output logic [MODE_W-1:0]   active_mode,
    output logic [SEL_W-1:0]    ide_cs_n,
    output logic [REG_W-1:0]    ide_a,
    output logic                ide_rd_n,
    output logic                ide_wr_n,
    output logic [DATA_W-1:0]   ide_dout,
    output logic                ide_doe,
    input  logic [DATA_W-1:0]   ide_din,
    input  logic                ide_rdy,
    input  logic                ide_iocs16_n
);
    localparam int HI_W = DATA_W - BYTE_W;

    pio_state_e st_q, st_d;
    logic [TCW-1:0]    cnt_q, tot_q;
    logic [MODE_W-1:0] mode_q, xmode_q, mode_next;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_q, byte_q, done_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              busy, narrow, setup_met, pulse_met, rec_met;
    logic [TCW-1:0]    pulse_need;

    assign mode_next  = (mode_set && (mode_val < MODE_W'(NUM_MODES))) ? mode_val : mode_q;
    assign narrow     = byte_q || ((xmode_q <= MODE_W'(NARROW_MAX_MODE)) && ide_iocs16_n);
    assign pulse_need = narrow ? tim.pulse_b : tim.pulse_w;
    assign setup_met  = cnt_q >= tim.setup;
    assign pulse_met  = cnt_q >= pulse_need;
    assign rec_met    = (cnt_q >= tim.recov) && (tot_q >= tim.cycle);

    // next-state decision
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (req_valid)             st_d = ST_SETUP;
            ST_SETUP:   if (setup_met)             st_d = ST_STROBE;
            ST_STROBE:  if (pulse_met && ide_rdy)  st_d = ST_RECOVER;
            ST_RECOVER: if (rec_met)               st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // counters and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            tot_q   <= '0;
            mode_q  <= '0;
            xmode_q <= '0;
            addr_q  <= '0;
            wr_q    <= 1'b0;
            byte_q  <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            if (st_q != st_d)        cnt_q <= TCW'(1);
            else if (cnt_q != '1)    cnt_q <= cnt_q + TCW'(1);

            if (st_q == ST_IDLE)     tot_q <= TCW'(1);
            else if (tot_q != '1)    tot_q <= tot_q + TCW'(1);

            if (st_q == ST_IDLE) begin
                mode_q <= mode_next;
                if (req_valid) begin
                    xmode_q <= mode_next;
                    addr_q  <= req_addr;
                    wr_q    <= req_write;
                    byte_q  <= req_byte;
                    wdata_q <= req_byte ? {{HI_W{1'b0}}, req_wdata[BYTE_W-1:0]} : req_wdata;
                end
            end

            if (st_q == ST_STROBE && st_d == ST_RECOVER && !wr_q)
                rdata_q <= narrow ? {{HI_W{1'b0}}, ide_din[BYTE_W-1:0]} : ide_din;

            done_q <= (st_q == ST_RECOVER) && (st_d == ST_IDLE);
        end
    end

    // outputs
    always_comb begin
        busy        = (st_q != ST_IDLE);
        req_ready   = !busy;
        done        = done_q;
        rdata       = rdata_q;
        active_mode = mode_q;
        xfer_mode   = xmode_q;
        ide_cs_n    = busy ? ~addr_q[ADDR_W-1:REG_W] : '1;
        ide_a       = busy ? addr_q[REG_W-1:0] : '0;
        ide_rd_n    = !((st_q == ST_STROBE) && !wr_q);
        ide_wr_n    = !((st_q == ST_STROBE) && wr_q);
        ide_dout    = wdata_q;
        ide_doe     = wr_q && ((st_q == ST_SETUP) || (st_q == ST_STROBE) ||
                               ((st_q == ST_RECOVER) && (cnt_q == TCW'(1))));
    end

    a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(ide_a) && $stable(ide_cs_n)));

    a_r5_rdy_stretches: assert property (@(posedge clk) disable iff (!rst_n)
        (!ide_rd_n && !ide_rdy) |=> !ide_rd_n);

    a_r5_rdy_stretches_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (!ide_wr_n && !ide_rdy) |=> !ide_wr_n);

    a_r7_cycle_min: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(tot_q) >= $past(tim.cycle)));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_oe_with_wr: assert property (@(posedge clk) disable iff (!rst_n)
        !ide_wr_n |-> ide_doe);

    a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(active_mode));
endmodule

// File: rtl/pio_host_seq.sv
`timescale 1ns/1ps
module pio_host_seq
    import pio_pkg::*;
#(
    parameter int CLK_NS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_byte,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic                mode_set,
    input  logic [MODE_W-1:0]   mode_val,
    output logic                req_ready,
    output logic                done,
    output logic [DATA_W-1:0]   rdata,
    output logic [MODE_W-1:0]   active_mode,
    output logic [SEL_W-1:0]    ide_cs_n,
    output logic [REG_W-1:0]    ide_a,
    output logic                ide_rd_n,
    output logic                ide_wr_n,
    output logic [DATA_W-1:0]   ide_dout,
    output logic                ide_doe,
    input  logic [DATA_W-1:0]   ide_din,
    input  logic                ide_rdy,
    input  logic                ide_iocs16_n
);
    pio_timing_t       tim;
    logic [MODE_W-1:0] xfer_mode;

    pio_timing_lut #(.CLK_NS(CLK_NS)) u_lut (
        .mode (xfer_mode),
        .tim  (tim)
    );

    pio_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_byte     (req_byte),
        .req_wdata    (req_wdata),
        .mode_set     (mode_set),
        .mode_val     (mode_val),
        .tim          (tim),
        .xfer_mode    (xfer_mode),
        .req_ready    (req_ready),
        .done         (done),
        .rdata        (rdata),
        .active_mode  (active_mode),
        .ide_cs_n     (ide_cs_n),
        .ide_a        (ide_a),
        .ide_rd_n     (ide_rd_n),
        .ide_wr_n     (ide_wr_n),
        .ide_dout     (ide_dout),
        .ide_doe      (ide_doe),
        .ide_din      (ide_din),
        .ide_rdy      (ide_rdy),
        .ide_iocs16_n (ide_iocs16_n)
    );
endmodule

// File: tb/tb_pio_host_seq.sv
`timescale 1ns/1ps
module tb_pio_host_seq;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_write = 0, req_byte = 0, mode_set = 0;
    logic [4:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [2:0]  mode_val = '0;
    logic        req_ready, done, ide_rd_n, ide_wr_n, ide_doe;
    logic [15:0] rdata, ide_dout;
    logic [2:0]  active_mode, ide_a;
    logic [1:0]  ide_cs_n;
    logic [15:0] ide_din = '0;
    logic        ide_rdy = 1'b1;
    logic        ide_iocs16_n = 1'b0;

    int n_chk = 0, n_bad = 0, cyc_cnt = 0;
    bit cmp_on = 0;

    pio_host_seq #(.CLK_NS(CLK_PERIOD)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_byte(req_byte), .req_wdata(req_wdata),
        .mode_set(mode_set), .mode_val(mode_val), .req_ready(req_ready),
        .done(done), .rdata(rdata), .active_mode(active_mode),
        .ide_cs_n(ide_cs_n), .ide_a(ide_a), .ide_rd_n(ide_rd_n), .ide_wr_n(ide_wr_n),
        .ide_dout(ide_dout), .ide_doe(ide_doe), .ide_din(ide_din),
        .ide_rdy(ide_rdy), .ide_iocs16_n(ide_iocs16_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int S_NS[7]   = '{70, 50, 30, 30, 25, 15, 10};
    int P16_NS[7] = '{165, 125, 100, 80, 70, 65, 55};
    int P8_NS[7]  = '{290, 290, 290, 80, 70, 65, 55};
    int R_NS[7]   = '{0, 0, 0, 70, 25, 25, 20};
    int C_NS[7]   = '{600, 383, 240, 180, 120, 100, 80};

    function automatic int cy(input int ns);
        return (ns + CLK_PERIOD - 1) / CLK_PERIOD;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference, advanced on each rising edge
    int m_ph = 0, m_pc = 0, m_tot = 0, m_mode = 0, m_tm = 0;
    bit m_w = 0, m_b = 0, m_done = 0;
    logic [4:0]  m_addr = '0;
    logic [15:0] m_wd = '0, m_rdata = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_mode = 0; m_done = 0; m_rdata = '0; m_w = 0;
        end else begin
            m_done = 0;
            case (m_ph)
                0: begin
                    if (mode_set && int'(mode_val) < 7) m_mode = int'(mode_val);
                    if (req_valid) begin
                        m_ph = 1; m_pc = 1; m_tot = 1; m_tm = m_mode;
                        m_addr = req_addr; m_w = req_write; m_b = req_byte;
                        m_wd = req_byte ? {8'h00, req_wdata[7:0]} : req_wdata;
                    end
                end
                1: begin
                    if (m_pc >= cy(S_NS[m_tm])) begin m_ph = 2; m_pc = 1; end
                    else m_pc++;
                    m_tot++;
                end
                2: begin
                    bit nar;
                    int need;
                    nar  = m_b || (m_tm <= 2 && ide_iocs16_n);
                    need = nar ? cy(P8_NS[m_tm]) : cy(P16_NS[m_tm]);
                    if (m_pc >= need && ide_rdy) begin
                        m_ph = 3; m_pc = 1;
                        if (!m_w) m_rdata = nar ? {8'h00, ide_din[7:0]} : ide_din;
                    end else m_pc++;
                    m_tot++;
                end
                default: begin
                    if (m_pc >= cy(R_NS[m_tm]) && m_tot >= cy(C_NS[m_tm])) begin
                        m_ph = 0; m_done = 1;
                    end else begin m_pc++; m_tot++; end
                end
            endcase
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (cmp_on) begin
            bit e_busy;
            e_busy = (m_ph != 0);
            chk(req_ready == !e_busy, "R11 req_ready", req_ready, !e_busy);
            chk(ide_cs_n == (e_busy ? ~m_addr[4:3] : 2'b11), "R2 cs_n", ide_cs_n,
                e_busy ? ~m_addr[4:3] : 2'b11);
            chk(ide_a == (e_busy ? m_addr[2:0] : 3'b000), "R2 addr", ide_a,
                e_busy ? m_addr[2:0] : 3'b000);
            chk(ide_rd_n == !(m_ph == 2 && !m_w), "R4 rd_n", ide_rd_n, !(m_ph == 2 && !m_w));
            chk(ide_wr_n == !(m_ph == 2 && m_w), "R4 wr_n", ide_wr_n, !(m_ph == 2 && m_w));
            chk(ide_doe == (m_w && (m_ph == 1 || m_ph == 2 || (m_ph == 3 && m_pc == 1))),
                "R9 doe", ide_doe, m_w && (m_ph == 1 || m_ph == 2 || (m_ph == 3 && m_pc == 1)));
            if (ide_doe) chk(ide_dout == m_wd, "R9 dout", ide_dout, m_wd);
            chk(done == m_done, "R8 done", done, m_done);
            if (m_done && !m_w) chk(rdata == m_rdata, "R8 rdata", rdata, m_rdata);
            chk(int'(active_mode) == m_mode, "R10 mode", active_mode, m_mode);
        end
    end

    // device side: data from pins, ready stalls, strobe measurement
    int stall_len = 0, lowc = 0, wcnt = 0, last_w = 0, su = 0, last_su = 0;
    bit seen = 0;
    always @(negedge clk) begin
        logic [4:0] f;
        bit lo;
        f  = {ide_cs_n, ide_a};
        lo = !ide_rd_n || !ide_wr_n;
        ide_din <= {3'b110, f, 3'b001, f};
        if (lo) lowc++; else lowc = 0;
        ide_rdy <= !(stall_len > 0 && lowc >= 2 && lowc < 2 + stall_len);
        if (lo) begin
            if (!seen) last_su = su;
            seen = 1; wcnt++;
        end else begin
            if (wcnt > 0) last_w = wcnt;
            wcnt = 0;
            if (req_ready) begin su = 0; seen = 0; end
            else if (!seen) su++;
        end
    end

    int bench_mode = 0;

    task automatic set_mode(input logic [2:0] v);
        @(negedge clk);
        mode_set = 1; mode_val = v;
        @(negedge clk);
        mode_set = 0;
        if (v < 7) bench_mode = int'(v);
    endtask

    task automatic run_op(input bit w, input logic [4:0] ad, input bit b,
                          input logic [15:0] wd, input int stall, input bit c16n,
                          input bit mset, input logic [2:0] mv, input int poke_at);
        int cycles, md, need, ew, etot;
        bit nar;
        logic [4:0] f;
        logic [15:0] exp_rd;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        stall_len = stall; ide_iocs16_n = c16n;
        req_write = w; req_addr = ad; req_byte = b; req_wdata = wd;
        mode_set = mset; mode_val = mv; req_valid = 1;
        if (mset && mv < 7) bench_mode = int'(mv);
        md = bench_mode;
        @(negedge clk);
        req_valid = 0; mode_set = 0;
        cycles = 1;
        forever begin
            if (cycles == poke_at) begin
                req_valid = 1; req_addr = 5'b11111; mode_set = 1; mode_val = 3'd5;
            end else begin
                req_valid = 0; mode_set = 0;
            end
            @(negedge clk);
            if (done) break;
            cycles++;
        end
        req_valid = 0; mode_set = 0;
        nar  = b || (md <= 2 && c16n);
        need = nar ? cy(P8_NS[md]) : cy(P16_NS[md]);
        ew   = (stall > 0) ? imax(need, 2 + stall) : need;
        etot = imax(cy(S_NS[md]) + ew + imax(cy(R_NS[md]), 1), cy(C_NS[md]));
        chk(last_su == cy(S_NS[md]), "R3 setup cycles", last_su, cy(S_NS[md]));
        if (stall > 0) chk(last_w == ew, "R5 stretched width", last_w, ew);
        else if (!b && c16n) chk(last_w == ew, "R6 narrow width", last_w, ew);
        else chk(last_w == ew, "R4 strobe width", last_w, ew);
        chk(cycles == etot, "R7 total cycles", cycles, etot);
        if (!w) begin
            f = {~ad[4:3], ad[2:0]};
            exp_rd = nar ? {8'h00, 3'b001, f} : {3'b110, f, 3'b001, f};
            chk(rdata == exp_rd, nar ? "R6 R8 narrow data" : "R8 read data", rdata, exp_rd);
        end
        chk(int'(active_mode) == bench_mode, "R10 mode kept", active_mode, bench_mode);
        stall_len = 0; ide_iocs16_n = 0;
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ide_cs_n == 2'b11 && ide_a == 3'b000, "R1 address idle", {ide_cs_n, ide_a}, 5'b11000);
        chk(ide_rd_n && ide_wr_n && !ide_doe, "R1 strobes idle", {ide_rd_n, ide_wr_n, ide_doe}, 3'b110);
        chk(!done && req_ready && active_mode == 3'd0, "R1 status", {done, req_ready, active_mode}, 5'b01000);
        rst_n = 1;
        @(negedge clk);
        cmp_on = 1;

        for (int m = 0; m < 7; m++) begin
            set_mode(3'(m));
            run_op(1, {2'b01, 3'(m)}, 0, 16'hA5C0 + 16'(m), 0, 0, 0, 0, 0);
            run_op(0, 5'b01000, 0, 16'h0, 0, 0, 0, 0, 0);
            run_op(0, 5'b10110, 1, 16'h0, 0, 0, 0, 0, 0);
            run_op(1, 5'b10001, 1, 16'hBEEF, 0, 0, 0, 0, 0);
        end
        // R5 ready stall on read and write
        set_mode(3'd3);
        run_op(0, 5'b01111, 0, 16'h0, 12, 0, 0, 0, 0);
        run_op(1, 5'b01010, 0, 16'h7E81, 9, 0, 0, 0, 0);
        // R6 narrow indicator honoured in mode 1, ignored in mode 4
        set_mode(3'd1);
        run_op(0, 5'b01000, 0, 16'h0, 0, 1, 0, 0, 0);
        set_mode(3'd4);
        run_op(0, 5'b01000, 0, 16'h0, 0, 1, 0, 0, 0);
        // R10 R11 mode change and new request while busy are ignored
        set_mode(3'd0);
        run_op(0, 5'b01011, 0, 16'h0, 0, 0, 0, 0, 10);
        @(negedge clk);
        chk(req_ready && ide_cs_n == 2'b11, "R11 no extra access", {req_ready, ide_cs_n}, 3'b111);
        // R10 out-of-range mode ignored
        set_mode(3'd7);
        chk(active_mode == 3'd0, "R10 mode 7 ignored", active_mode, 0);
        // R10 mode set together with request applies to it
        run_op(0, 5'b10010, 0, 16'h0, 0, 0, 1, 3'd2, 0);
        chk(active_mode == 3'd2, "R10 same-cycle mode", active_mode, 2);

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule